// File: doc/BRIEF.md
# Call Gate Transfer Sequencer

This block runs the memory side of an inter-ring far call through a call gate, and of the matching far return. Privilege checks and descriptor lookup have already been done by the time it starts. For a call it is given the caller's code selector, instruction pointer, stack selector and stack pointer, along with the decoded gate: a target code selector, an entry offset held as two half-words, a parameter count and a slot size. It reads the inner stack selector and pointer from the task state area at a base address, builds the inner stack frame and reports the new CS, IP, SS and SP. For a return it unwinds that frame, skipping a given number of parameter bytes.

All stack and task-state traffic goes over one word-wide memory port with a request/ready handshake. A pulse on `start` while the block is idle captures every operand. `busy` stays high until the one-cycle `done` pulse, and the result outputs are valid from that pulse onward. A wide gate uses 4-byte slots carrying full 32-bit words. A narrow gate uses 2-byte slots carrying only the low half-word.

Top module: `gateXferSeq`

## Requirements
- R1: During and right after reset, `busy`, `done` and `memReq` are low and `newCs`, `newIp`, `newSs` and `newSp` are zero.
- R2: `start` is accepted only while `busy` is low. A `start` pulse while busy has no effect on the operation in progress. After an accepted start, `busy` is high from the next cycle through the cycle of `done`, `done` is high for exactly one cycle, and `busy` is low in the cycle after `done`.
- R3: A call first reads the inner SP and then the inner SS from the task state area, with `memSel` = 0. Take ring r = low two bits of the gate selector and slot size s (4 wide, 2 narrow). The SP is read at `trBase` + 2·s·r + s and the SS at `trBase` + 2·s·r + 2·s. The SS is the low 16 bits of the word read.
- R4: The call then saves the caller's stack by writing the old SS and then the old SP onto the inner stack (`memSel` = inner SS). Each write goes to the current inner SP minus s, and that lowered value becomes the new inner SP.
- R5: Let k be the parameter count. The call then copies k slots, alternating a read and a write. The reads come from the old stack at old SP + i·s. The writes go to the inner stack at (saved-SP slot address − k·s) + i·s, for i = 0 up to k−1 in that order. With k = 0 no copy access happens.
- R6: The call ends with two pushes below the copied block: first the return CS, then the return IP. The final `newSp` is the address of the IP slot.
- R7: When a call completes, `newCs` equals the gate selector and `newSs` equals the task-state SS. `newIp` is {offset high, offset low} for a wide gate and the zero-extended low half for a narrow gate. `newCpl` equals the low two bits of `newCs`.
- R8: In narrow mode every word written carries the value's low 16 bits with the upper 16 bits zero, and every value read (IP, SP, parameters) keeps only its low 16 bits. In wide mode all 32 bits are carried.
- R9: A return (`opReturn` = 1) reads the current stack on `curSs` at `curSp` (IP), `curSp`+s (CS), `curSp`+2s+n (SP) and `curSp`+3s+n (SS), where n is `discardBytes`. It reports these values as `newIp`, `newCs`, `newSp` and `newSs`.
- R10: Exactly one memory access completes in each cycle that has both `memReq` and `memReady` high. While `memReady` is low, `memReq`, `memWe`, `memSel`, `memAddr` and `memWdata` hold their values.
- R11: `memReq` is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (accepted when idle) |
| opReturn | input | 1 | 1 = far return, 0 = call through gate |
| gateWide | input | 1 | 1 = 4-byte slots, 0 = 2-byte slots |
| curCs | input | 16 | Caller code selector |
| curIp | input | 32 | Caller return instruction pointer |
| curSs | input | 16 | Current stack selector |
| curSp | input | 32 | Current stack pointer |
| gateSel | input | 16 | Target code selector from the gate |
| gateOffLo | input | 16 | Low half of the gate entry offset |
| gateOffHi | input | 16 | High half of the gate entry offset |
| paramCnt | input | 5 | Number of parameter slots to copy |
| trBase | input | 32 | Base address of the task state area |
| discardBytes | input | 16 | Parameter bytes skipped on return |
| memReq | output | 1 | Memory access request |
| memWe | output | 1 | 1 = write, 0 = read |
| memSel | output | 16 | Segment selector of the access (0 = task state) |
| memAddr | output | 32 | Byte offset of the access |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data, valid with memReady |
| memReady | input | 1 | Access completes this cycle |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| newCs | output | 16 | Resulting code selector |
| newIp | output | 32 | Resulting instruction pointer |
| newSs | output | 16 | Resulting stack selector |
| newSp | output | 32 | Resulting stack pointer |
| newCpl | output | 2 | Privilege level after the transfer |

## Verification
The bench logs every completed memory access and compares the whole sequence against a frame model. A design that pushed SP before SS, copied parameters in reverse, or decremented after writing would show up as an out-of-place or shifted entry. The corner cases driven are a zero parameter count, where a block that still fetched one slot would log extra accesses, and the full 31-slot count, where a counter that wrapped early would stop short. Narrow gates are run with junk in the upper half of every stored word, so a datapath that forgot to mask would pass that junk into the IP, SP or parameters. Call/return round trips with a discard of exactly the copied bytes must restore the caller's registers, and a `start` pulse injected mid-call with different operands must leave the results unchanged.

// File: rtl/gate_xfer_pkg.sv
package gate_xfer_pkg;

  typedef enum logic [3:0] {
    S_IDLE,
    S_TSS_SP,
    S_TSS_SS,
    S_PUSH_SS,
    S_PUSH_SP,
    S_CP_RD,
    S_CP_WR,
    S_PUSH_CS,
    S_PUSH_IP,
    S_POP_IP,
    S_POP_CS,
    S_POP_SP,
    S_POP_SS,
    S_FIN
  } seqState_t;

  // control -> datapath strobes
  typedef struct packed {
    logic      capture;  // operands latched this cycle
    logic      fire;     // memory handshake completes this cycle
    seqState_t step;     // which access is on the port
  } seqStrobe_t;

endpackage

// File: rtl/gateSeqCtrl.sv
module gateSeqCtrl
  import gate_xfer_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  logic       isReturn,
  input  logic       memReady,
  input  logic       copyNone,
  input  logic       copyLast,
  output seqStrobe_t strobe,
  output logic       memReq,
  output logic       busy,
  output logic       done
);

  seqState_t state, nextState;
  logic fire;

  always_comb begin
    memReq = !(state == S_IDLE || state == S_FIN);
    fire   = memReq && memReady;
    nextState = state;
    case (state)
      S_IDLE:    if (start) nextState = isReturn ? S_POP_IP : S_TSS_SP;
      S_TSS_SP:  if (fire) nextState = S_TSS_SS;
      S_TSS_SS:  if (fire) nextState = S_PUSH_SS;
      S_PUSH_SS: if (fire) nextState = S_PUSH_SP;
      S_PUSH_SP: if (fire) nextState = copyNone ? S_PUSH_CS : S_CP_RD;
      S_CP_RD:   if (fire) nextState = S_CP_WR;
      S_CP_WR:   if (fire) nextState = copyLast ? S_PUSH_CS : S_CP_RD;
      S_PUSH_CS: if (fire) nextState = S_PUSH_IP;
      S_PUSH_IP: if (fire) nextState = S_FIN;
      S_POP_IP:  if (fire) nextState = S_POP_CS;
      S_POP_CS:  if (fire) nextState = S_POP_SP;
      S_POP_SP:  if (fire) nextState = S_POP_SS;
      S_POP_SS:  if (fire) nextState = S_FIN;
      S_FIN:     nextState = S_IDLE;
      default:   nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign busy = (state != S_IDLE);
  assign done = (state == S_FIN);
  assign strobe.capture = (state == S_IDLE) && start;
  assign strobe.fire    = fire;
  assign strobe.step    = state;

endmodule

// File: rtl/gateSeqPath.sv
module gateSeqPath
  import gate_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 5,
  parameter int HW = AW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  seqStrobe_t    strobe,
  input  logic          gateWide,
  input  logic [SW-1:0] curCs,
  input  logic [AW-1:0] curIp,
  input  logic [SW-1:0] curSs,
  input  logic [AW-1:0] curSp,
  input  logic [SW-1:0] gateSel,
  input  logic [HW-1:0] gateOffLo,
  input  logic [HW-1:0] gateOffHi,
  input  logic [CW-1:0] paramCnt,
  input  logic [AW-1:0] trBase,
  input  logic [HW-1:0] discardBytes,
  input  logic [AW-1:0] memRdata,
  output logic          memWe,
  output logic [SW-1:0] memSel,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWdata,
  output logic          copyNone,
  output logic          copyLast,
  output logic [SW-1:0] newCs,
  output logic [AW-1:0] newIp,
  output logic [SW-1:0] newSs,
  output logic [AW-1:0] newSp
);

  localparam logic [AW-1:0] WIDE_SLOT   = AW'(AW / 8);
  localparam logic [AW-1:0] NARROW_SLOT = AW'(AW / 16);

  logic          wide;
  logic [SW-1:0] cs0, ss0, gSel, ssNew;
  logic [AW-1:0] ip0, sp0, gOff, trB, spNew, srcPtr, dstPtr, tmp;
  logic [CW-1:0] cntLeft;
  logic [HW-1:0] disc;

  logic [AW-1:0] slot, ringBase, pushAddr, cntBytes;

  function automatic logic [AW-1:0] fitSlot(input logic [AW-1:0] v, input logic w);
    return w ? v : {{(AW-HW){1'b0}}, v[HW-1:0]};
  endfunction

  function automatic logic [AW-1:0] selWord(input logic [SW-1:0] s);
    return {{(AW-SW){1'b0}}, s};
  endfunction

  always_comb begin
    slot     = wide ? WIDE_SLOT : NARROW_SLOT;
    ringBase = trB + (AW'(gSel[1:0]) * (slot << 1));
    pushAddr = spNew - slot;
    cntBytes = AW'(cntLeft) * slot;
  end

  assign copyNone = (cntLeft == '0);
  assign copyLast = (cntLeft == CW'(1));

  // memory port decode
  always_comb begin
    memWe    = 1'b0;
    memSel   = '0;
    memAddr  = '0;
    memWdata = '0;
    case (strobe.step)
      S_TSS_SP:  memAddr = ringBase + slot;
      S_TSS_SS:  memAddr = ringBase + (slot << 1);
      S_PUSH_SS: begin memWe = 1'b1; memSel = ssNew; memAddr = pushAddr; memWdata = selWord(ss0); end
      S_PUSH_SP: begin memWe = 1'b1; memSel = ssNew; memAddr = pushAddr; memWdata = fitSlot(sp0, wide); end
      S_CP_RD:   begin memSel = ss0; memAddr = srcPtr; end
      S_CP_WR:   begin memWe = 1'b1; memSel = ssNew; memAddr = dstPtr; memWdata = tmp; end
      S_PUSH_CS: begin memWe = 1'b1; memSel = ssNew; memAddr = pushAddr; memWdata = selWord(cs0); end
      S_PUSH_IP: begin memWe = 1'b1; memSel = ssNew; memAddr = pushAddr; memWdata = fitSlot(ip0, wide); end
      S_POP_IP, S_POP_CS, S_POP_SP, S_POP_SS: begin memSel = ssNew; memAddr = spNew; end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wide <= 1'b0; cs0 <= '0; ip0 <= '0; ss0 <= '0; sp0 <= '0;
      gSel <= '0; gOff <= '0; trB <= '0; cntLeft <= '0; disc <= '0;
      ssNew <= '0; spNew <= '0; srcPtr <= '0; dstPtr <= '0; tmp <= '0;
      newCs <= '0; newIp <= '0; newSs <= '0; newSp <= '0;
    end else if (strobe.capture) begin
      wide    <= gateWide;
      cs0     <= curCs;
      ip0     <= curIp;
      ss0     <= curSs;
      sp0     <= curSp;
      gSel    <= gateSel;
      gOff    <= {gateOffHi, gateOffLo};
      trB     <= trBase;
      cntLeft <= paramCnt;
      disc    <= discardBytes;
      ssNew   <= curSs;
      spNew   <= curSp;
    end else if (strobe.fire) begin
      case (strobe.step)
        S_TSS_SP:  spNew <= fitSlot(memRdata, wide);
        S_TSS_SS:  ssNew <= memRdata[SW-1:0];
        S_PUSH_SS: spNew <= pushAddr;
        S_PUSH_SP: begin
          spNew  <= pushAddr - cntBytes;
          dstPtr <= pushAddr - cntBytes;
          srcPtr <= sp0;
        end
        S_CP_RD: begin
          tmp    <= fitSlot(memRdata, wide);
          srcPtr <= srcPtr + slot;
        end
        S_CP_WR: begin
          dstPtr  <= dstPtr + slot;
          cntLeft <= cntLeft - CW'(1);
        end
        S_PUSH_CS: spNew <= pushAddr;
        S_PUSH_IP: begin
          spNew <= pushAddr;
          newCs <= gSel;
          newIp <= fitSlot(gOff, wide);
          newSs <= ssNew;
          newSp <= pushAddr;
        end
        S_POP_IP: begin
          newIp <= fitSlot(memRdata, wide);
          spNew <= spNew + slot;
        end
        S_POP_CS: begin
          newCs <= memRdata[SW-1:0];
          spNew <= spNew + slot + AW'(disc);
        end
        S_POP_SP: begin
          tmp   <= fitSlot(memRdata, wide);
          spNew <= spNew + slot;
        end
        S_POP_SS: begin
          newSs <= memRdata[SW-1:0];
          newSp <= tmp;
          spNew <= spNew + slot;
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/gateXferSeq.sv
module gateXferSeq
  import gate_xfer_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 16,
  parameter int CW = 5,
  parameter int HW = AW / 2
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          start,
  input  logic          opReturn,
  input  logic          gateWide,
  input  logic [SW-1:0] curCs,
  input  logic [AW-1:0] curIp,
  input  logic [SW-1:0] curSs,
  input  logic [AW-1:0] curSp,
  input  logic [SW-1:0] gateSel,
  input  logic [HW-1:0] gateOffLo,
  input  logic [HW-1:0] gateOffHi,
  input  logic [CW-1:0] paramCnt,
  input  logic [AW-1:0] trBase,
  input  logic [HW-1:0] discardBytes,
  output logic          memReq,
  output logic          memWe,
  output logic [SW-1:0] memSel,
  output logic [AW-1:0] memAddr,
  output logic [AW-1:0] memWdata,
  input  logic [AW-1:0] memRdata,
  input  logic          memReady,
  output logic          busy,
  output logic          done,
  output logic [SW-1:0] newCs,
  output logic [AW-1:0] newIp,
  output logic [SW-1:0] newSs,
  output logic [AW-1:0] newSp,
  output logic [1:0]    newCpl
);

  seqStrobe_t strobe;
  logic copyNone, copyLast;

  gateSeqCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .start    (start),
    .isReturn (opReturn),
    .memReady (memReady),
    .copyNone (copyNone),
    .copyLast (copyLast),
    .strobe   (strobe),
    .memReq   (memReq),
    .busy     (busy),
    .done     (done)
  );

  gateSeqPath #(.AW(AW), .SW(SW), .CW(CW), .HW(HW)) u_path (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .gateWide     (gateWide),
    .curCs        (curCs),
    .curIp        (curIp),
    .curSs        (curSs),
    .curSp        (curSp),
    .gateSel      (gateSel),
    .gateOffLo    (gateOffLo),
    .gateOffHi    (gateOffHi),
    .paramCnt     (paramCnt),
    .trBase       (trBase),
    .discardBytes (discardBytes),
    .memRdata     (memRdata),
    .memWe        (memWe),
    .memSel       (memSel),
    .memAddr      (memAddr),
    .memWdata     (memWdata),
    .copyNone     (copyNone),
    .copyLast     (copyLast),
    .newCs        (newCs),
    .newIp        (newIp),
    .newSs        (newSs),
    .newSp        (newSp)
  );

  assign newCpl = newCs[1:0];

endmodule

// File: rtl/gateXferSeqChk.sv
module gateXferSeqChk #(
  parameter int AW = 32,
  parameter int SW = 16
) (
  input logic          clk,
  input logic          rstN,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          memReq,
  input logic          memReady,
  input logic          memWe,
  input logic [SW-1:0] memSel,
  input logic [AW-1:0] memAddr,
  input logic [AW-1:0] memWdata
);

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (memReq && !memReady) |=> (memReq && $stable(memWe) && $stable(memSel)
                               && $stable(memAddr) && $stable(memWdata)));

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memReq);

  // R2
  start_take_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R2
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> (!done && !busy));

  // R2
  run_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !done) |=> busy);

endmodule

bind gateXferSeq gateXferSeqChk #(.AW(AW), .SW(SW)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .start    (start),
  .busy     (busy),
  .done     (done),
  .memReq   (memReq),
  .memReady (memReady),
  .memWe    (memWe),
  .memSel   (memSel),
  .memAddr  (memAddr),
  .memWdata (memWdata)
);

// File: tb/gateXferSeq_bench.sv
`timescale 1ns/1ps
module gateXferSeq_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0, opReturn = 1'b0, gateWide = 1'b0;
  logic [15:0] curCs = '0, curSs = '0, gateSel = '0, gateOffLo = '0, gateOffHi = '0, discardBytes = '0;
  logic [31:0] curIp = '0, curSp = '0, trBase = '0;
  logic [4:0]  paramCnt = '0;
  logic        memReq, memWe, memReady, busy, done;
  logic [15:0] memSel, newCs, newSs;
  logic [31:0] memAddr, memWdata, memRdata, newIp, newSp;
  logic [1:0]  newCpl;

  always #4 clk = ~clk;

  gateXferSeq u_gateXferSeq (
    .clk(clk), .rstN(rstN), .start(start), .opReturn(opReturn), .gateWide(gateWide),
    .curCs(curCs), .curIp(curIp), .curSs(curSs), .curSp(curSp),
    .gateSel(gateSel), .gateOffLo(gateOffLo), .gateOffHi(gateOffHi),
    .paramCnt(paramCnt), .trBase(trBase), .discardBytes(discardBytes),
    .memReq(memReq), .memWe(memWe), .memSel(memSel), .memAddr(memAddr),
    .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady),
    .busy(busy), .done(done), .newCs(newCs), .newIp(newIp), .newSs(newSs),
    .newSp(newSp), .newCpl(newCpl)
  );

  typedef struct packed {
    logic        we;
    logic [15:0] sel;
    logic [31:0] addr;
    logic [31:0] data;
  } acc_t;

  acc_t gotLog [0:127];
  acc_t expLog [0:127];
  int   gotN = 0, expN = 0;
  int   checks = 0, fails = 0;
  bit   finished = 0;
  bit   readyAlways = 1;
  logic [31:0] mem [logic [47:0]];

  // caller state of the last call, used for round trips
  logic [15:0] oCs, oSs;
  logic [31:0] oIp, oSp;

  function automatic logic [31:0] fitV(input logic [31:0] v, input logic w);
    return w ? v : {16'h0, v[15:0]};
  endfunction

  function automatic logic [31:0] slotOf(input logic w);
    return w ? 32'd4 : 32'd2;
  endfunction

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic addExp(input logic we, input logic [15:0] sel, input logic [31:0] addr,
                        input logic [31:0] data);
    expLog[expN] = '{we, sel, addr, data};
    expN++;
  endtask

  task automatic cmpLog(input int lo, input int hi, input string tag);
    int bad = -1;
    for (int i = lo; i < hi; i++)
      if (bad < 0 && gotLog[i] !== expLog[i]) bad = i;
    checks++;
    if (bad >= 0) begin
      fails++;
      $display("FAIL %s entry %0d actual=%h expected=%h", tag, bad, gotLog[bad], expLog[bad]);
    end
  endtask

  // memory responder: decides ready away from the edge, commits the access
  always @(negedge clk) begin
    logic [47:0] key;
    if (!rstN) begin
      memReady = 1'b0;
      memRdata = '0;
    end else begin
      memReady = readyAlways || ($urandom_range(0, 2) != 0);
      memRdata = $urandom;
      if (memReq && memReady) begin
        key = {memSel, memAddr};
        if (memWe) mem[key] = memWdata;
        else memRdata = mem.exists(key) ? mem[key] : 32'h0;
        if (gotN < 128) gotLog[gotN] = '{memWe, memSel, memAddr, memWe ? memWdata : 32'h0};
        gotN++;
      end
    end
  end

  task automatic waitDone(input string tag);
    int n = 0;
    while (!done && n < 3000) begin
      @(negedge clk);
      n++;
    end
    chk({tag, " R2 done seen"}, {63'h0, done}, 64'h1);
    chk({tag, " R2 busy with done"}, {63'h0, busy}, 64'h1);
    @(negedge clk);
    chk({tag, " R2 done one cycle"}, {62'h0, done, busy}, 64'h0);
  endtask

  task automatic runCall(input bit w, input logic [1:0] ring, input int cnt, input bit poke);
    logic [31:0] s, tb, tssSp, base, p, ringOff;
    logic [15:0] tssSs, gs, lo, hi;
    logic [31:0] pv [0:31];
    s = slotOf(w);
    oCs = 16'($urandom) | 16'h3;
    oIp = $urandom;
    oSs = 16'h0100 + 16'($urandom_range(0, 255));
    oSp = 32'h5000 + ($urandom_range(0, 127) << 4);
    gs = {14'($urandom), ring};
    lo = 16'($urandom);
    hi = 16'($urandom);
    tb = 32'h0001_0000 + ($urandom_range(0, 255) << 6);
    tssSp = 32'h9000 + ($urandom_range(0, 127) << 4);
    tssSs = 16'h0200 + 16'($urandom_range(0, 255));
    ringOff = 32'(ring) * 2 * s;
    mem[{16'h0, tb + ringOff + s}] = w ? tssSp : {16'($urandom), tssSp[15:0]};
    mem[{16'h0, tb + ringOff + 2 * s}] = {16'($urandom), tssSs};
    for (int i = 0; i < cnt; i++) begin
      pv[i] = $urandom;
      mem[{oSs, oSp + 32'(i) * s}] = pv[i];
    end
    expN = 0;
    addExp(1'b0, 16'h0, tb + ringOff + s, 32'h0);
    addExp(1'b0, 16'h0, tb + ringOff + 2 * s, 32'h0);
    p = tssSp - s;      addExp(1'b1, tssSs, p, {16'h0, oSs});
    p = p - s;          addExp(1'b1, tssSs, p, fitV(oSp, w));
    base = p - 32'(cnt) * s;
    for (int i = 0; i < cnt; i++) begin
      addExp(1'b0, oSs, oSp + 32'(i) * s, 32'h0);
      addExp(1'b1, tssSs, base + 32'(i) * s, fitV(pv[i], w));
    end
    p = base - s;       addExp(1'b1, tssSs, p, {16'h0, oCs});
    p = p - s;          addExp(1'b1, tssSs, p, fitV(oIp, w));

    gotN = 0;
    opReturn = 1'b0; gateWide = w; curCs = oCs; curIp = oIp; curSs = oSs; curSp = oSp;
    gateSel = gs; gateOffLo = lo; gateOffHi = hi; paramCnt = 5'(cnt); trBase = tb;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R2 busy after start", {63'h0, busy}, 64'h1);
    if (poke) begin
      @(negedge clk);
      curCs = ~oCs; curIp = ~oIp; curSs = ~oSs; gateSel = ~gs; paramCnt = ~5'(cnt);
      trBase = ~tb; gateWide = ~w; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    waitDone("call");
    chk("R10 access count", 64'(gotN), 64'(expN));
    cmpLog(0, 2, "R3 task state reads");
    cmpLog(2, 4, "R4 outer stack save");
    cmpLog(4, 4 + 2 * cnt, "R5 parameter copy");
    cmpLog(4 + 2 * cnt, expN, "R6 return push");
    chk("R7 newCs", 64'(newCs), 64'(gs));
    chk("R7 R8 newIp", 64'(newIp), w ? 64'({hi, lo}) : 64'(lo));
    chk("R3 R7 newSs", 64'(newSs), 64'(tssSs));
    chk("R6 newSp", 64'(newSp), 64'(p));
    chk("R7 newCpl", 64'(newCpl), 64'(ring));
  endtask

  task automatic runRet(input bit w, input logic [15:0] ss, input logic [31:0] sp,
                        input logic [15:0] n, input logic [31:0] eIp, input logic [15:0] eCs,
                        input logic [15:0] eSs, input logic [31:0] eSp, input string tag);
    logic [31:0] s;
    s = slotOf(w);
    expN = 0;
    addExp(1'b0, ss, sp, 32'h0);
    addExp(1'b0, ss, sp + s, 32'h0);
    addExp(1'b0, ss, sp + 2 * s + 32'(n), 32'h0);
    addExp(1'b0, ss, sp + 3 * s + 32'(n), 32'h0);
    gotN = 0;
    opReturn = 1'b1; gateWide = w; curSs = ss; curSp = sp; discardBytes = n;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    opReturn = 1'b0;
    chk({tag, " R2 busy after start"}, {63'h0, busy}, 64'h1);
    waitDone(tag);
    chk({tag, " R10 access count"}, 64'(gotN), 64'(expN));
    cmpLog(0, 4, {tag, " R9 pop addresses"});
    chk({tag, " R9 R8 newIp"}, 64'(newIp), 64'(eIp));
    chk({tag, " R9 newCs"}, 64'(newCs), 64'(eCs));
    chk({tag, " R9 newSs"}, 64'(newSs), 64'(eSs));
    chk({tag, " R9 R8 newSp"}, 64'(newSp), 64'(eSp));
  endtask

  task automatic plainRet(input bit w, input logic [15:0] n);
    logic [31:0] s, sp, ip, spv;
    logic [15:0] ss, cs, ssv;
    s = slotOf(w);
    ss = 16'h0300 + 16'($urandom_range(0, 255));
    sp = 32'h7000 + ($urandom_range(0, 127) << 4);
    ip = $urandom; cs = 16'($urandom); spv = $urandom; ssv = 16'($urandom);
    mem[{ss, sp}] = ip;
    mem[{ss, sp + s}] = {16'($urandom), cs};
    mem[{ss, sp + 2 * s + 32'(n)}] = spv;
    mem[{ss, sp + 3 * s + 32'(n)}] = {16'($urandom), ssv};
    runRet(w, ss, sp, n, fitV(ip, w), cs, ssv, fitV(spv, w), "ret");
  endtask

  task automatic roundTrip(input bit w, input int cnt);
    runRet(w, newSs, newSp, 16'(32'(cnt) * slotOf(w)), fitV(oIp, w), oCs, oSs, fitV(oSp, w), "trip");
  endtask

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      fails++;
      checks++;
      $display("FAIL R10 watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (4) @(negedge clk);
    // R1 reset state
    chk("R1 control in reset", {61'h0, busy, done, memReq}, 64'h0);
    chk("R1 outputs in reset", {newCs, newSs, newIp[15:0], newSp[15:0]} | {32'h0, newIp[31:16], newSp[31:16]}, 64'h0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R1 control after reset", {61'h0, busy, done, memReq}, 64'h0);
    chk("R11 idle no request", {63'h0, memReq}, 64'h0);

    // directed corners with an always-ready memory
    runCall(1'b1, 2'd0, 0, 1'b0);  roundTrip(1'b1, 0);
    runCall(1'b0, 2'd1, 3, 1'b0);  roundTrip(1'b0, 3);
    runCall(1'b1, 2'd2, 31, 1'b1); roundTrip(1'b1, 31);
    plainRet(1'b1, 16'd0);
    plainRet(1'b0, 16'd6);

    // random traffic with stalls
    readyAlways = 0;
    for (int k = 0; k < 40; k++) begin
      bit w;
      int c;
      w = 1'($urandom_range(0, 1));
      c = $urandom_range(0, 8);
      runCall(w, 2'($urandom_range(0, 2)), c, 1'($urandom_range(0, 1)));
      roundTrip(w, c);
    end
    for (int k = 0; k < 10; k++)
      plainRet(1'($urandom_range(0, 1)), 16'($urandom_range(0, 12) * 2));
    runCall(1'b0, 2'd2, 0, 1'b1);
    roundTrip(1'b0, 0);

    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule